// File: doc/BRIEF.md
# Conversion Result Store with Overrun Flags

This block sits between a multi-channel converter sequencer and a register bus. Each finished conversion arrives as a one-cycle result strobe carrying a channel index and a data word. An accepted result is kept in that channel's own data register and also in a shared last-result register. Per-channel end-of-conversion flags, per-channel overrun flags, a global data-ready flag and a global overrun flag record what software has not yet collected.

Reads use a strobe and an address. The read data is combinational for the address presented. Each flag is cleared by the clock edge that ends the read of the register it belongs to. Overrun is tracked twice. Per channel, it is measured against that channel's end-of-conversion flag and kept in a separate overrun register. Globally, it is measured against data-ready and sits in the status register.

The sequencer also sends a start strobe per channel. If a channel's enable input changes while its conversion is pending, results for that channel are dropped until its next start strobe, because their data is meaningless.

Top module: `conv_result_flags`

## Requirements
- R1: After synchronous reset every flag and every data register is zero, so every readable address returns zero.
- R2: An accepted result is stored in its channel register (address 3 + channel) and in the last-result register (address 2). The last-result register holds the data in bits DW-1:0 and the channel index in the bits directly above.
- R3: An accepted result sets that channel's end-of-conversion flag. The status register (address 0) holds the end-of-conversion flags in bits NCH-1:0 (bit i for channel i), data-ready in bit NCH and the global overrun flag in bit NCH+1.
- R4: Reading a channel data register clears that channel's end-of-conversion flag and no other flag.
- R5: An accepted result for a channel whose end-of-conversion flag is set before that clock edge sets the channel's overrun flag. The overrun register (address 1) holds bit i for channel i.
- R6: Reading the overrun register clears all per-channel overrun flags.
- R7: Any accepted result sets data-ready. Reading the last-result register clears it.
- R8: An accepted result that arrives while data-ready is set sets the global overrun flag. Reading the status register clears that flag.
- R9: When a flag is set and cleared by a read in the same cycle, it ends set. The read still returns the value from before that edge.
- R10: A result is dropped, and changes no data or flag, if its channel's enable is low, or if that enable changed while a conversion was pending on the channel and no start strobe for the channel has come since. A result strobe ends the pending state whether or not it is accepted.
- R11: With the read strobe high, an address above 2 + NCH returns zero and clears nothing. With the read strobe low, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Sequencer starts a conversion |
| start_chan | input | CH_W | Channel of the started conversion |
| chan_en | input | NCH | Per-channel enable |
| res_valid | input | 1 | Conversion result strobe |
| res_chan | input | CH_W | Channel of the result |
| res_data | input | DW | Result value |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register address |
| rd_data | output | RD_W | Read data for rd_addr |

## Verification
Each channel is first given one result that is collected in full. This separates the channel-register, last-result, data-ready and end-of-conversion paths, because every channel carries a different data word. Repeated results without reads then separate the per-channel overrun from the global overrun. Reads that coincide with a result on the same channel show whether the set beats the clear. Enable changes around start strobes separate a disabled-channel drop from a mid-conversion drop. A long pseudo-random mix of starts, results, enable flips and reads at every address is then checked against an arithmetic model of all flags and registers.

// File: rtl/conv_pkg.sv
// Register address constants shared by the result store and its bench.
// Assumes the channel registers occupy a contiguous range after the
// fixed registers.
package conv_pkg;
    localparam int ADDR_STATUS = 0;
    localparam int ADDR_OVR    = 1;
    localparam int ADDR_LAST   = 2;
    localparam int ADDR_CH0    = 3;
endpackage

// File: rtl/conv_accept_gate.sv
// Decides whether an incoming result is kept. It tracks, per channel,
// whether a conversion is pending and whether the enable changed while
// it was pending. Assumes one result strobe per cycle at most.
module conv_accept_gate #(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_valid,
    input  logic [CH_W-1:0] start_chan,
    input  logic [NCH-1:0]  chan_en,
    input  logic            res_valid,
    input  logic [CH_W-1:0] res_chan,
    output logic [NCH-1:0]  acc_vec,
    output logic            accept
);
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] dirty_q;
    logic [NCH-1:0] chg;

    assign chg = chan_en ^ en_q;

    // Per-channel keep decision for the current result strobe.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            acc_vec[i] = res_valid && (res_chan == CH_W'(i)) && chan_en[i]
                         && !(dirty_q[i] || (pend_q[i] && chg[i]));
        end
    end

    assign accept = |acc_vec;

    // Track the previous enables and the pending and tainted state per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            pend_q  <= '0;
            dirty_q <= '0;
        end else begin
            en_q <= chan_en;
            for (int i = 0; i < NCH; i++) begin
                if (start_valid && start_chan == CH_W'(i)) begin
                    pend_q[i]  <= 1'b1;
                    dirty_q[i] <= 1'b0;
                end else begin
                    if (res_valid && res_chan == CH_W'(i))
                        pend_q[i] <= 1'b0;
                    if (pend_q[i] && chg[i])
                        dirty_q[i] <= 1'b1;
                end
            end
        end
    end

    // R10
    drop_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !chan_en[res_chan]) |-> !accept);
    // R10
    drop_tainted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && dirty_q[res_chan]) |-> !accept);
endmodule

// File: rtl/conv_chan_slot.sv
// One channel's data register with its end-of-conversion and overrun
// flags. A set in the same cycle as a clear wins. Assumes set is a
// single-cycle strobe from the accept gate.
module conv_chan_slot #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic [DW-1:0] din,
    input  logic          data_rd,
    input  logic          ovr_rd,
    output logic [DW-1:0] data_q,
    output logic          eoc_q,
    output logic          ovr_q
);
    // Capture data and update the channel flags, set beating clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            eoc_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (set)
                data_q <= din;
            if (set)
                eoc_q <= 1'b1;
            else if (data_rd)
                eoc_q <= 1'b0;
            if (set && eoc_q)
                ovr_q <= 1'b1;
            else if (ovr_rd)
                ovr_q <= 1'b0;
        end
    end

    // R3
    eoc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_q) |-> $past(set));
    // R9
    eoc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> eoc_q);
    // R5
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(eoc_q));
endmodule

// File: rtl/conv_global_flags.sv
// Shared last-result register with the data-ready and global overrun
// flags. Assumes accept is a single-cycle strobe qualified upstream.
module conv_global_flags #(
    parameter int DW   = 10,
    parameter int CH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [CH_W-1:0]    res_chan,
    input  logic [DW-1:0]      res_data,
    input  logic               last_rd,
    input  logic               stat_rd,
    output logic [CH_W+DW-1:0] last_q,
    output logic               drdy_q,
    output logic               govr_q
);
    // Capture the last result and update the global flags, set beating clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            drdy_q <= 1'b0;
            govr_q <= 1'b0;
        end else begin
            if (accept)
                last_q <= {res_chan, res_data};
            if (accept)
                drdy_q <= 1'b1;
            else if (last_rd)
                drdy_q <= 1'b0;
            if (accept && drdy_q)
                govr_q <= 1'b1;
            else if (stat_rd)
                govr_q <= 1'b0;
        end
    end

    // R7
    drdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> drdy_q);
    // R8
    govr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(govr_q) |-> $past(drdy_q));
    // R2
    last_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (last_q == $past({res_chan, res_data})));
endmodule

// File: rtl/conv_read_mux.sv
// Combinational register read selection. Returns zero when the strobe
// is low or the address is unmapped. Assumes flat packed channel data.
module conv_read_mux #(
    parameter int NCH    = 8,
    parameter int DW     = 10,
    parameter int CH_W   = 3,
    parameter int ADDR_W = 4,
    parameter int RD_W   = 13
) (
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [NCH*DW-1:0]  data_flat,
    input  logic [NCH-1:0]     eoc,
    input  logic [NCH-1:0]     ovr,
    input  logic [CH_W+DW-1:0] last,
    input  logic               drdy,
    input  logic               govr,
    output logic [RD_W-1:0]    rd_data
);
    import conv_pkg::*;

    // Select the addressed register value.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (rd_addr == ADDR_W'(ADDR_STATUS))
                rd_data = RD_W'({govr, drdy, eoc});
            else if (rd_addr == ADDR_W'(ADDR_OVR))
                rd_data = RD_W'(ovr);
            else if (rd_addr == ADDR_W'(ADDR_LAST))
                rd_data = RD_W'(last);
            else begin
                for (int i = 0; i < NCH; i++) begin
                    if (rd_addr == ADDR_W'(ADDR_CH0 + i))
                        rd_data = RD_W'(data_flat[i*DW +: DW]);
                end
            end
        end
    end
endmodule

// File: rtl/conv_result_flags.sv
// Top level: result gate, per-channel slots, global flags and read mux.
// Assumes reads and results may coincide in any cycle; clears take
// effect at the edge that ends the read.
module conv_result_flags #(
    parameter int NCH = 8,
    parameter int DW  = 10,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ADDR_W = $clog2(NCH + 3),
    localparam int RD_W   = ((CH_W + DW) > (NCH + 2)) ? (CH_W + DW) : (NCH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [CH_W-1:0]   start_chan,
    input  logic [NCH-1:0]    chan_en,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [DW-1:0]     res_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data
);
    import conv_pkg::*;

    logic [NCH-1:0]     acc_vec;
    logic               accept;
    logic [NCH*DW-1:0]  data_flat;
    logic [NCH-1:0]     eoc;
    logic [NCH-1:0]     ovr;
    logic [CH_W+DW-1:0] last;
    logic               drdy;
    logic               govr;
    logic               stat_rd;
    logic               ovr_rd;
    logic               last_rd;

    assign stat_rd = rd_en && (rd_addr == ADDR_W'(ADDR_STATUS));
    assign ovr_rd  = rd_en && (rd_addr == ADDR_W'(ADDR_OVR));
    assign last_rd = rd_en && (rd_addr == ADDR_W'(ADDR_LAST));

    conv_accept_gate #(.NCH(NCH), .CH_W(CH_W)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_chan(start_chan),
        .chan_en(chan_en), .res_valid(res_valid), .res_chan(res_chan),
        .acc_vec(acc_vec), .accept(accept)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic data_rd;
        assign data_rd = rd_en && (rd_addr == ADDR_W'(ADDR_CH0 + g));
        conv_chan_slot #(.DW(DW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .set(acc_vec[g]), .din(res_data),
            .data_rd(data_rd), .ovr_rd(ovr_rd),
            .data_q(data_flat[g*DW +: DW]), .eoc_q(eoc[g]), .ovr_q(ovr[g])
        );
    end

    conv_global_flags #(.DW(DW), .CH_W(CH_W)) u_glob (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .res_chan(res_chan), .res_data(res_data),
        .last_rd(last_rd), .stat_rd(stat_rd),
        .last_q(last), .drdy_q(drdy), .govr_q(govr)
    );

    conv_read_mux #(.NCH(NCH), .DW(DW), .CH_W(CH_W), .ADDR_W(ADDR_W), .RD_W(RD_W)) u_mux (
        .rd_en(rd_en), .rd_addr(rd_addr), .data_flat(data_flat),
        .eoc(eoc), .ovr(ovr), .last(last), .drdy(drdy), .govr(govr),
        .rd_data(rd_data)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (eoc == '0 && ovr == '0 && !drdy && !govr));
    // R11
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
endmodule

// File: tb/tb_conv_result_flags.sv
`timescale 1ns/1ps
module tb_conv_result_flags;
    localparam int NCH = 8;
    localparam int DW  = 10;
    localparam int CW  = 3;
    localparam int AW  = 4;
    localparam int RW  = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_valid = 1'b0;
    logic [CW-1:0] start_chan = '0;
    logic [NCH-1:0] chan_en = '1;
    logic          res_valid = 1'b0;
    logic [CW-1:0] res_chan = '0;
    logic [DW-1:0] res_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [RW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    int m_data[NCH];
    bit [NCH-1:0] m_eoc, m_ovr, m_pend, m_dirty, m_enq;
    bit m_drdy, m_govr;
    int m_last;

    always #10 clk = ~clk;

    conv_result_flags #(.NCH(NCH), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_chan(start_chan),
        .chan_en(chan_en), .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int model_read(input int a);
        if (a == 0) return (int'(m_govr) << (NCH + 1)) | (int'(m_drdy) << NCH) | int'(m_eoc);
        if (a == 1) return int'(m_ovr);
        if (a == 2) return m_last;
        if (a >= 3 && a < 3 + NCH) return m_data[a-3];
        return 0;
    endfunction

    // One clock cycle of stimulus, with the read checked against the model.
    task automatic step(input bit v, input int ch, input int d, input bit r, input int a,
                        input bit s, input int sc, input logic [NCH-1:0] en, input string req);
        bit [NCH-1:0] chg, pre_eoc;
        bit pre_drdy, acc;
        int exp;
        @(negedge clk);
        res_valid = v; res_chan = CW'(ch); res_data = DW'(d);
        rd_en = r; rd_addr = AW'(a); start_valid = s; start_chan = CW'(sc); chan_en = en;
        #2;
        exp = r ? model_read(a) : 0;
        total++;
        if (int'(rd_data) != exp) begin
            bad++;
            $display("FAIL %s addr=%0d rd=%0d got=%0h exp=%0h", req, a, r, rd_data, exp);
        end
        chg = en ^ m_enq;
        acc = v && en[ch] && !(m_dirty[ch] || (m_pend[ch] && chg[ch]));
        for (int i = 0; i < NCH; i++) begin
            if (s && sc == i) begin m_pend[i] = 1; m_dirty[i] = 0; end
            else begin
                if (m_pend[i] && chg[i]) m_dirty[i] = 1;
                if (v && ch == i) m_pend[i] = 0;
            end
        end
        pre_eoc = m_eoc; pre_drdy = m_drdy;
        if (r) begin
            if (a == 0) m_govr = 0;
            else if (a == 1) m_ovr = '0;
            else if (a == 2) m_drdy = 0;
            else if (a >= 3 && a < 3 + NCH) m_eoc[a-3] = 0;
        end
        if (acc) begin
            if (pre_eoc[ch]) m_ovr[ch] = 1;
            m_eoc[ch] = 1;
            if (pre_drdy) m_govr = 1;
            m_drdy = 1;
            m_data[ch] = d & ((1 << DW) - 1);
            m_last = (ch << DW) | (d & ((1 << DW) - 1));
        end
        m_enq = en;
        @(posedge clk);
    endtask

    task automatic put(input int ch, input int d, input logic [NCH-1:0] en, input string req);
        step(1, ch, d, 0, 0, 0, 0, en, req);
    endtask

    task automatic rd(input int a, input logic [NCH-1:0] en, input string req);
        step(0, 0, 0, 1, a, 0, 0, en, req);
    endtask

    initial begin
        #(20ns * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NCH-1:0] en;
        logic [31:0] lfsr;
        en = '1;
        for (int i = 0; i < NCH; i++) m_data[i] = 0;
        m_eoc = 0; m_ovr = 0; m_pend = 0; m_dirty = 0; m_enq = 0;
        m_drdy = 0; m_govr = 0; m_last = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: every address reads zero after reset
        for (int a = 0; a < 16; a++) rd(a, en, "R1");

        // R2 R3 R4 R7: one collected result per channel
        for (int c = 0; c < NCH; c++) begin
            put(c, (c * 97 + 13) & 1023, en, "R2");
            rd(0, en, "R3");
            rd(3 + c, en, "R2");
            rd(0, en, "R4");
            rd(2, en, "R7");
            rd(2, en, "R7");
        end
        put(0, 1023, en, "R2");
        rd(3, en, "R2");
        rd(2, en, "R2");

        // R5 R6: repeat on one channel without reading
        put(2, 5, en, "R5");
        put(2, 6, en, "R5");
        rd(1, en, "R5");
        rd(1, en, "R6");
        rd(4 + 1, en, "R5");

        // R8: results while data-ready is set
        put(6, 77, en, "R8");
        rd(0, en, "R8");
        rd(0, en, "R8");
        rd(2, en, "R8");

        // R9: set and clear in the same cycle
        step(1, 5, 300, 1, 3 + 5, 0, 0, en, "R9");
        rd(0, en, "R9");
        step(1, 5, 301, 1, 1, 0, 0, en, "R9");
        rd(1, en, "R9");
        step(1, 4, 302, 1, 2, 0, 0, en, "R9");
        rd(0, en, "R9");
        step(1, 4, 303, 1, 0, 0, 0, en, "R9");
        rd(0, en, "R9");

        // R10: disabled channel and enable change while pending
        en[3] = 1'b0;
        put(3, 999, en, "R10");
        rd(0, en, "R10");
        rd(3 + 3, en, "R10");
        en[3] = 1'b1;
        step(0, 0, 0, 0, 0, 1, 4, en, "R10");
        en[4] = 1'b0; rd(0, en, "R10");
        en[4] = 1'b1; rd(0, en, "R10");
        put(4, 444, en, "R10");
        rd(3 + 4, en, "R10");
        put(4, 445, en, "R10");
        rd(3 + 4, en, "R10");
        step(0, 0, 0, 0, 0, 1, 4, en, "R10");
        put(4, 446, en, "R10");
        rd(3 + 4, en, "R10");

        // R11: unmapped addresses and idle strobe
        put(1, 11, en, "R11");
        for (int a = 3 + NCH; a < 16; a++) rd(a, en, "R11");
        step(0, 0, 0, 0, 0, 0, 0, en, "R11");
        rd(0, en, "R11");

        // mixed pseudo-random traffic against the model
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[27:25] == 3'd0) en[lfsr[10:8]] = ~en[lfsr[10:8]];
            step(lfsr[0] | lfsr[1], int'(lfsr[4:2]), int'(lfsr[24:15]),
                 lfsr[5] | lfsr[6], int'(lfsr[14:11]),
                 lfsr[7] & lfsr[29], int'(lfsr[31:29]), en, "R9 mix");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule